// File: doc/BRIEF.md
# Peripheral Clock Gate and Wake Controller

This block decides whether the main clock reaches an external peripheral controller. Software can stop that clock to save power, or start it again. The peripheral can also ask for its clock on its own, by driving a rising edge on a request pin. That edge turns the clock on, records the request in a sticky status bit, and wakes a sleep/timing unit if that unit is asleep. The sleep unit itself sits outside this block; only its sleep-state signal and a wake-request line cross the boundary.

The forwarded clock goes through a latch-based gate, so every pulse on the output is either a full pulse or no pulse at all. While the forwarded clock is stopped, the serial handshake line toward the peripheral is held HIGH.

A small wake state machine follows the sleep unit. Its states are:
- `ST_IDLE`: no wake in progress.
- `ST_WAKE_REQ`: the wake-request output is raised.
- `ST_WOKEN`: a one-cycle wake-up state.

Its transitions are:
- `IDLE_TO_WAKE_REQ`: a request edge arrives while the sleep input is high.
- `WAKE_REQ_TO_WOKEN`: the sleep input drops.
- `WOKEN_TO_IDLE`: taken unconditionally.

Top module: `pclk_wake_ctrl`

## Requirements
- R1: After reset, the clock-enable bit (`clk_en_o`) is 0. While the gate holds 0, `periph_clk_o` stays LOW for the whole clock period.
- R2: While `clk_en_o` is 0, `uart_hs_o` is 1. While `clk_en_o` is 1, `uart_hs_o` follows `uart_hs_i`.
- R3: When `sw_wr_i` is 1 at a rising edge of `clk_i`, `clk_en_o` takes the value of `sw_clken_wdata_i` from that edge onward. The forwarded clock then produces full high pulses from the following cycle until the cycle after a write of 0. That last pulse is complete.
- R4: A LOW-to-HIGH change on `periph_req_i` passes through two synchronizer flops and an edge detector. At the third rising edge of `clk_i` after the pin rises, it sets both `clk_en_o` and `req_flag_o`. A falling edge, or a level held high, changes nothing.
- R5: If `sleep_state_i` is 1 when the request edge is taken in `ST_IDLE`, the block enters `ST_WAKE_REQ`. `wake_req_o` is then 1 from that edge until the sleep input drops.
- R6: When `sleep_state_i` drops in `ST_WAKE_REQ`, the block enters `ST_WOKEN` for exactly one cycle. In that cycle `irq_o` is 1 and `clk_en_o` is 1.
- R7: `req_flag_o` is never cleared by hardware. It stays 1 until a cycle with `sw_req_clr_i` at 1 clears it.
- R8: If a request edge falls in the same cycle as a software clear, `req_flag_o` ends up 1. If it falls in the same cycle as a software write of 0 to the clock enable, `clk_en_o` ends up 1.
- R9: A request edge taken while `sleep_state_i` is 0 raises neither `wake_req_o` nor `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock, also the clock that is forwarded |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_wr_i | input | 1 | Software write strobe for the clock-enable bit |
| sw_clken_wdata_i | input | 1 | Value written to the clock-enable bit |
| sw_req_clr_i | input | 1 | Software clear of the request status bit |
| periph_req_i | input | 1 | Asynchronous clock request from the peripheral |
| sleep_state_i | input | 1 | High while the sleep/timing unit is asleep |
| uart_hs_i | input | 1 | Handshake level from the serial receiver |
| periph_clk_o | output | 1 | Gated clock forwarded to the peripheral |
| uart_hs_o | output | 1 | Handshake to the peripheral, forced HIGH while the clock is stopped |
| clk_en_o | output | 1 | Clock-enable status bit |
| req_flag_o | output | 1 | Sticky request status bit |
| wake_req_o | output | 1 | Wake-up request to the sleep unit |
| irq_o | output | 1 | Interrupt, pulsed in the wake-up state |

## Verification
Two events can land in one cycle:
- A hardware request edge and a software clear of the request bit.
- A hardware request edge and a software write of 0 to the clock enable.

The bench raises the request pin and then waits two clock edges. It asserts both software strobes so that they are sampled at the same edge where the synchronized edge takes effect. It then expects both bits to read 1. A following cycle carrying only the clear and the write of 0 shows that each strobe still works on its own.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAKE_REQ = 2'd1,
        ST_WOKEN    = 2'd2
    } wake_state_e;

endpackage

// File: rtl/pwc_req_sync.sv
module pwc_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < CHAIN_W; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[g] <= 1'b0;
                    else         chain_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[g] <= 1'b0;
                    else         chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/pwc_clk_gate.sv
module pwc_clk_gate (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic gclk_o
);
    logic en_lat;

    always_latch begin
        if (!rst_ni)      en_lat = 1'b0;
        else if (!clk_i)  en_lat = en_i;
    end

    assign gclk_o = clk_i & en_lat;

endmodule

// File: rtl/pwc_ctrl_regs.sv
module pwc_ctrl_regs (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sw_wr_i,
    input  logic sw_wdata_i,
    input  logic sw_clr_i,
    input  logic req_edge_i,
    input  logic wake_set_i,
    output logic clk_en_q,
    output logic req_flag_q
);
    logic hw_set;

    assign hw_set = req_edge_i | wake_set_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            clk_en_q <= 1'b0;
        end else if (hw_set) begin
            clk_en_q <= 1'b1;
        end else if (sw_wr_i) begin
            clk_en_q <= sw_wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            req_flag_q <= 1'b0;
        end else if (req_edge_i) begin
            req_flag_q <= 1'b1;
        end else if (sw_clr_i) begin
            req_flag_q <= 1'b0;
        end
    end

    assert_sw_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sw_wr_i && sw_wdata_i |=> clk_en_q);

    assert_edge_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_edge_i |=> clk_en_q && req_flag_q);

    assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_flag_q && !sw_clr_i |=> req_flag_q);

    assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_edge_i && sw_wr_i && !sw_wdata_i |=> clk_en_q);

endmodule

// File: rtl/pwc_wake_fsm.sv
module pwc_wake_fsm
    import pwc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_edge_i,
    input  logic sleep_i,
    output logic wake_req_o,
    output logic irq_o,
    output logic wake_set_o
);
    wake_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_edge_i && sleep_i) state_d = ST_WAKE_REQ;
            ST_WAKE_REQ: if (!sleep_i)              state_d = ST_WOKEN;
            ST_WOKEN:                               state_d = ST_IDLE;
            default:                                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        wake_req_o = 1'b0;
        irq_o      = 1'b0;
        wake_set_o = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_WAKE_REQ: begin
                wake_req_o = 1'b1;
                wake_set_o = !sleep_i;
            end
            ST_WOKEN:    irq_o = 1'b1;
            default:     ;
        endcase
    end

    assert_wake_issue_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q == ST_IDLE && req_edge_i && sleep_i |=> wake_req_o);

    assert_irq_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |=> !irq_o);

    assert_awake_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q == ST_IDLE && req_edge_i && !sleep_i |=> !wake_req_o && !irq_o);

endmodule

// File: rtl/pclk_wake_ctrl.sv
module pclk_wake_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sw_wr_i,
    input  logic sw_clken_wdata_i,
    input  logic sw_req_clr_i,
    input  logic periph_req_i,
    input  logic sleep_state_i,
    input  logic uart_hs_i,
    output logic periph_clk_o,
    output logic uart_hs_o,
    output logic clk_en_o,
    output logic req_flag_o,
    output logic wake_req_o,
    output logic irq_o
);
    logic req_edge;
    logic wake_set;
    logic clk_en;
    logic req_flag;

    pwc_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (periph_req_i),
        .rise_o  (req_edge)
    );

    pwc_wake_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .req_edge_i (req_edge),
        .sleep_i    (sleep_state_i),
        .wake_req_o (wake_req_o),
        .irq_o      (irq_o),
        .wake_set_o (wake_set)
    );

    pwc_ctrl_regs u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sw_wr_i    (sw_wr_i),
        .sw_wdata_i (sw_clken_wdata_i),
        .sw_clr_i   (sw_req_clr_i),
        .req_edge_i (req_edge),
        .wake_set_i (wake_set),
        .clk_en_q   (clk_en),
        .req_flag_q (req_flag)
    );

    pwc_clk_gate u_gate (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (clk_en),
        .gclk_o (periph_clk_o)
    );

    assign uart_hs_o  = clk_en ? uart_hs_i : 1'b1;
    assign clk_en_o   = clk_en;
    assign req_flag_o = req_flag;

    assert_irq_clock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> clk_en_o);

    assert_wake_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wake_req_o) |-> req_flag_o && clk_en_o);

endmodule

// File: tb/pclk_wake_ctrl_tb_top.sv
module pclk_wake_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_wr = 1'b0, sw_wd = 1'b0, sw_clr = 1'b0;
    logic preq = 1'b0, sleep = 1'b0, hs_in = 1'b0;
    logic pclk, hs_out, clk_en, req_flag, wake_req, irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic last_en = 1'b0;
    logic gmid = 1'b0;

    string      tag_q[$];
    logic [5:0] val_q[$];

    always #4 clk = ~clk;

    pclk_wake_ctrl dut_i (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .sw_wr_i          (sw_wr),
        .sw_clken_wdata_i (sw_wd),
        .sw_req_clr_i     (sw_clr),
        .periph_req_i     (preq),
        .sleep_state_i    (sleep),
        .uart_hs_i        (hs_in),
        .periph_clk_o     (pclk),
        .uart_hs_o        (hs_out),
        .clk_en_o         (clk_en),
        .req_flag_o       (req_flag),
        .wake_req_o       (wake_req),
        .irq_o            (irq)
    );

    // Gated clock sampled in the middle of the high phase.
    initial forever begin
        @(posedge clk);
        #2 gmid = pclk;
    end

    task automatic cmp(string tag, string name, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", tag, name, act, exp);
        end
    endtask

    // Monitor: pops expected items and compares at the falling edge.
    initial forever begin
        @(negedge clk);
        if (tag_q.size() > 0) begin
            string t;
            logic [5:0] v;
            t = tag_q.pop_front();
            v = val_q.pop_front();
            cmp(t, "clk_en",   clk_en,   v[5]);
            cmp(t, "req_flag", req_flag, v[4]);
            cmp(t, "wake_req", wake_req, v[3]);
            cmp(t, "irq",      irq,      v[2]);
            cmp(t, "uart_hs",  hs_out,   v[1]);
            cmp(t, "gclk_mid", gmid,     v[0]);
        end
    end

    // Driver: one clock edge, push the expectation, return after the monitor.
    task automatic tick(string tag, logic en, logic fl, logic wr, logic iq, logic hs);
        @(posedge clk);
        #1;
        tag_q.push_back(tag);
        val_q.push_back({en, fl, wr, iq, hs, last_en});
        last_en = en;
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        tick("R1 reset state", 0, 0, 0, 0, 1);
        tick("R1 clock held low", 0, 0, 0, 0, 1);

        // R3 software start
        sw_wr = 1; sw_wd = 1;
        tick("R3 write one", 1, 0, 0, 0, 0);
        sw_wr = 0;
        tick("R3 clock running", 1, 0, 0, 0, 0);
        hs_in = 1;
        tick("R2 handshake follows", 1, 0, 0, 0, 1);
        hs_in = 0;
        tick("R2 handshake follows low", 1, 0, 0, 0, 0);

        // R3 software stop, last pulse complete
        sw_wr = 1; sw_wd = 0;
        tick("R3 write zero", 0, 0, 0, 0, 1);
        sw_wr = 0;
        tick("R1 stopped clock low", 0, 0, 0, 0, 1);

        // R4 / R9 request edge while awake
        preq = 1;
        tick("R4 sync stage 1", 0, 0, 0, 0, 1);
        tick("R4 sync stage 2", 0, 0, 0, 0, 1);
        tick("R4 R9 edge sets bits", 1, 1, 0, 0, 0);
        tick("R4 clock started", 1, 1, 0, 0, 0);
        tick("R7 held level no change", 1, 1, 0, 0, 0);
        preq = 0;
        tick("R4 falling edge ignored", 1, 1, 0, 0, 0);
        tick("R7 sticky", 1, 1, 0, 0, 0);
        tick("R7 sticky", 1, 1, 0, 0, 0);
        sw_clr = 1;
        tick("R7 software clear", 1, 0, 0, 0, 0);
        sw_clr = 0;
        sw_wr = 1; sw_wd = 0;
        tick("R3 stop before sleep test", 0, 0, 0, 0, 1);
        sw_wr = 0;
        tick("R1 stopped", 0, 0, 0, 0, 1);

        // R5 / R6 wake sequence
        sleep = 1; preq = 1;
        tick("R5 stage 1", 0, 0, 0, 0, 1);
        tick("R5 stage 2", 0, 0, 0, 0, 1);
        tick("R5 wake request issued", 1, 1, 1, 0, 0);
        tick("R5 wake request held", 1, 1, 1, 0, 0);
        sleep = 0;
        tick("R6 woken state irq", 1, 1, 0, 1, 0);
        tick("R6 irq one cycle", 1, 1, 0, 0, 0);

        // R8 edge coincides with clear and write zero
        preq = 0;
        tick("R8 prep", 1, 1, 0, 0, 0);
        tick("R8 prep", 1, 1, 0, 0, 0);
        tick("R8 prep", 1, 1, 0, 0, 0);
        preq = 1;
        tick("R8 stage 1", 1, 1, 0, 0, 0);
        tick("R8 stage 2", 1, 1, 0, 0, 0);
        sw_clr = 1; sw_wr = 1; sw_wd = 0;
        tick("R8 edge wins", 1, 1, 0, 0, 0);
        tick("R8 strobes alone", 0, 0, 0, 0, 1);
        sw_clr = 0; sw_wr = 0;
        tick("R1 after strobes", 0, 0, 0, 0, 1);

        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule